// File: doc/BRIEF.md
# Serial Port Control and Status Register Bank

This block is the software-visible register file of a serial peripheral. A single-cycle, word-addressed bus reads and writes it. The block holds the control register, the secondary control register, the baud divisor and the status register. The status register combines live fields, driven by the FIFOs beside it, with sticky error flags that hardware sets.

The control, secondary control and status registers each take four consecutive word slots. The first slot loads the register. The other three clear, set or invert only the bits that are 1 in the write data, so software can change one field without a read-modify-write. A data-buffer slot does not store anything. A write there becomes a push strobe with its data toward the transmit queue. A read there returns the head of the receive queue together with a pop strobe. Read data is combinational from the current state in the same cycle as the read. Write effects appear after the next clock edge.

Top module: `spi_csr_bank`

## Requirements
- R1: After reset, the control, secondary control and baud registers and all three sticky flags are zero. A status read then returns only the live fields.
- R2: A write to word 0 (byte offset 0x00) loads all 32 control bits, and later reads of word 0 return that value.
- R3: A write to word 1, 2 or 3 (byte offsets 0x04/0x08/0x0C) changes the control register as reg & ~d, reg | d or reg ^ d respectively.
- R4: A read of any alias word (clear, set, invert) of the control, status or secondary control register returns the value of the base register.
- R5: Word 12 (byte offset 0x30) is the baud divisor. A write keeps write-data bits 8:0 only, and a read returns them with bits 31:9 zero.
- R6: Words 16 to 19 (byte offsets 0x40 to 0x4C) hold the secondary control register, with the same load/clear/set/invert behaviour as R2 and R3. Its bits 10, 11 and 12 are the enables for the underrun, overrun and frame-error interrupts.
- R7: A status read (words 4 to 7) returns the receive-empty input in bit 5, the transmit level in bits 20:16 and the receive level in bits 28:24. Software writes never change these live fields.
- R8: A one-cycle event pulse sets its sticky flag: receive overrun is bit 6, transmit underrun bit 8 and frame error bit 12. The flag stays set while no software write clears it.
- R9: Writing a 1 to a flag's bit position at the status clear alias (word 5, byte offset 0x14) clears that flag. Writing 0 there leaves it unchanged.
- R10: When a hardware event and a software clear of the same flag fall in the same cycle, the flag ends up set.
- R11: A write to word 8 (byte offset 0x20) pulses the push strobe for that cycle only, with the write data on the push data output. A read of word 8 pulses the pop strobe and returns the receive-queue data.
- R12: Reserved words 9 to 11, 13 to 15 and every word above 19 read as zero, and writes to them change no register.
- R13: A direct write (word 4), set alias (word 6) or invert alias (word 7) of the status register loads, sets or toggles only the three sticky flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe |
| bus_word | input | WA_W (6) | Word address, equal to byte offset / 4 |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| ctrl_o | output | 32 | Control register contents |
| ctrl2_o | output | 32 | Secondary control register contents |
| baud_o | output | 9 | Baud divisor |
| txq_push | output | 1 | Push strobe to the transmit queue |
| txq_data | output | 32 | Data for the transmit queue |
| rxq_pop | output | 1 | Pop strobe to the receive queue |
| rxq_data | input | 32 | Head of the receive queue |
| txq_level | input | 5 | Transmit queue fill level |
| rxq_level | input | 5 | Receive queue fill level |
| rxq_empty | input | 1 | Receive queue empty |
| evt_rx_ovf | input | 1 | Receive overrun event pulse |
| evt_tx_udr | input | 1 | Transmit underrun event pulse |
| evt_frame | input | 1 | Frame error event pulse |

## Verification
The bench targets alias semantics with patterns where clear, set and invert each give different results. A design that treated an alias as a plain load would then show a wrong control value on the next cycle. It hits the status register with all-ones writes through every alias to show that the live level and empty fields cannot be written. It also drives an event in the same cycle as a clear of that flag, so a design that lets software win would lose an overrun report. Reserved slots and the baud register get all-ones writes. A sloppy decoder would alias these onto a real register, and a missing mask would leak bits above 8.

// File: rtl/spi_csr_pkg.sv
package spi_csr_pkg;

    localparam int DATA_W  = 32;
    localparam int BAUD_W  = 9;
    localparam int LVL_W   = 5;
    localparam int NFLAG   = 3;

    // status bit positions
    localparam int POS_RX_EMPTY = 5;
    localparam int POS_TX_LVL   = 16;
    localparam int POS_RX_LVL   = 24;
    // sticky flags: index 0 overrun, 1 underrun, 2 frame error
    localparam int FLAG_POS [NFLAG] = '{6, 8, 12};

    // group numbers (word address bits above the two alias bits)
    localparam int GRP_CTRL  = 0;
    localparam int GRP_STAT  = 1;
    localparam int GRP_BUF   = 2;
    localparam int GRP_BAUD  = 3;
    localparam int GRP_CTRL2 = 4;

    typedef enum logic [2:0] {
        WOP_NONE,
        WOP_LOAD,
        WOP_CLR,
        WOP_SET,
        WOP_FLIP
    } wop_e;

    typedef enum logic [2:0] {
        TGT_NONE,
        TGT_CTRL,
        TGT_STAT,
        TGT_BUF,
        TGT_BAUD,
        TGT_CTRL2
    } tgt_e;

    typedef struct packed {
        tgt_e tgt;
        wop_e op;
    } dec_t;

endpackage

// File: rtl/spi_csr_decode.sv
module spi_csr_decode
    import spi_csr_pkg::*;
#(
    parameter int WA_W = 6
) (
    input  logic [WA_W-1:0] word,
    output dec_t            dec
);
    localparam int GRP_W = WA_W - 2;

    logic [GRP_W-1:0] grp;
    logic [1:0]       sub;
    wop_e             alias_op;

    always_comb begin
        grp = word[WA_W-1:2];
        sub = word[1:0];
        case (sub)
            2'd0:    alias_op = WOP_LOAD;
            2'd1:    alias_op = WOP_CLR;
            2'd2:    alias_op = WOP_SET;
            default: alias_op = WOP_FLIP;
        endcase

        dec.tgt = TGT_NONE;
        dec.op  = WOP_NONE;
        if (grp == GRP_W'(GRP_CTRL)) begin
            dec.tgt = TGT_CTRL;
            dec.op  = alias_op;
        end else if (grp == GRP_W'(GRP_STAT)) begin
            dec.tgt = TGT_STAT;
            dec.op  = alias_op;
        end else if (grp == GRP_W'(GRP_CTRL2)) begin
            dec.tgt = TGT_CTRL2;
            dec.op  = alias_op;
        end else if (sub == 2'd0 && grp == GRP_W'(GRP_BUF)) begin
            dec.tgt = TGT_BUF;
            dec.op  = WOP_LOAD;
        end else if (sub == 2'd0 && grp == GRP_W'(GRP_BAUD)) begin
            dec.tgt = TGT_BAUD;
            dec.op  = WOP_LOAD;
        end
    end
endmodule

// File: rtl/spi_csr_alias_reg.sv
module spi_csr_alias_reg
    import spi_csr_pkg::*;
#(
    parameter int           W   = 32,
    parameter logic [W-1:0] RST = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wen,
    input  wop_e         op,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);
    typedef struct packed {
        logic [W-1:0] val;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wen) begin
            case (op)
                WOP_LOAD: st_d.val = wdata;
                WOP_CLR:  st_d.val = st_q.val & ~wdata;
                WOP_SET:  st_d.val = st_q.val | wdata;
                WOP_FLIP: st_d.val = st_q.val ^ wdata;
                default:  st_d.val = st_q.val;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{val: RST};
        else        st_q <= st_d;
    end

    assign q = st_q.val;
endmodule

// File: rtl/spi_csr_flags.sv
module spi_csr_flags
    import spi_csr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sw_en,
    input  wop_e             op,
    input  logic [NFLAG-1:0] sw_bits,
    input  logic [NFLAG-1:0] evt,
    output logic [NFLAG-1:0] flags
);
    typedef struct packed {
        logic [NFLAG-1:0] f;
    } st_t;

    st_t st_d, st_q;
    logic [NFLAG-1:0] sw_next;

    always_comb begin
        sw_next = st_q.f;
        if (sw_en) begin
            case (op)
                WOP_LOAD: sw_next = sw_bits;
                WOP_CLR:  sw_next = st_q.f & ~sw_bits;
                WOP_SET:  sw_next = st_q.f | sw_bits;
                WOP_FLIP: sw_next = st_q.f ^ sw_bits;
                default:  sw_next = st_q.f;
            endcase
        end
        // a hardware event outranks any software change in the same cycle
        st_d.f = sw_next | evt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flags = st_q.f;
endmodule

// File: rtl/spi_csr_bank.sv
module spi_csr_bank
    import spi_csr_pkg::*;
#(
    parameter int WA_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [WA_W-1:0]   bus_word,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic [31:0]       ctrl_o,
    output logic [31:0]       ctrl2_o,
    output logic [8:0]        baud_o,
    output logic              txq_push,
    output logic [31:0]       txq_data,
    output logic              rxq_pop,
    input  logic [31:0]       rxq_data,
    input  logic [4:0]        txq_level,
    input  logic [4:0]        rxq_level,
    input  logic              rxq_empty,
    input  logic              evt_rx_ovf,
    input  logic              evt_tx_udr,
    input  logic              evt_frame
);
    dec_t             dec;
    logic [NFLAG-1:0] flag_q;
    logic [NFLAG-1:0] flag_wbits;
    logic [DATA_W-1:0] stat_word;

    spi_csr_decode #(.WA_W(WA_W)) u_dec (
        .word (bus_word),
        .dec  (dec)
    );

    spi_csr_alias_reg #(.W(DATA_W)) u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .wen   (bus_wr && dec.tgt == TGT_CTRL),
        .op    (dec.op),
        .wdata (bus_wdata),
        .q     (ctrl_o)
    );

    spi_csr_alias_reg #(.W(DATA_W)) u_ctrl2 (
        .clk   (clk),
        .rst_n (rst_n),
        .wen   (bus_wr && dec.tgt == TGT_CTRL2),
        .op    (dec.op),
        .wdata (bus_wdata),
        .q     (ctrl2_o)
    );

    spi_csr_alias_reg #(.W(BAUD_W)) u_baud (
        .clk   (clk),
        .rst_n (rst_n),
        .wen   (bus_wr && dec.tgt == TGT_BAUD),
        .op    (dec.op),
        .wdata (bus_wdata[BAUD_W-1:0]),
        .q     (baud_o)
    );

    always_comb begin
        for (int i = 0; i < NFLAG; i++) flag_wbits[i] = bus_wdata[FLAG_POS[i]];
    end

    spi_csr_flags u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .sw_en   (bus_wr && dec.tgt == TGT_STAT),
        .op      (dec.op),
        .sw_bits (flag_wbits),
        .evt     ({evt_frame, evt_tx_udr, evt_rx_ovf}),
        .flags   (flag_q)
    );

    always_comb begin
        stat_word = '0;
        stat_word[POS_RX_EMPTY] = rxq_empty;
        stat_word[POS_TX_LVL +: LVL_W] = txq_level;
        stat_word[POS_RX_LVL +: LVL_W] = rxq_level;
        for (int i = 0; i < NFLAG; i++) stat_word[FLAG_POS[i]] = flag_q[i];
    end

    always_comb begin
        case (dec.tgt)
            TGT_CTRL:  bus_rdata = ctrl_o;
            TGT_CTRL2: bus_rdata = ctrl2_o;
            TGT_STAT:  bus_rdata = stat_word;
            TGT_BUF:   bus_rdata = rxq_data;
            TGT_BAUD:  bus_rdata = {{(DATA_W-BAUD_W){1'b0}}, baud_o};
            default:   bus_rdata = '0;
        endcase
    end

    assign txq_push = bus_wr && dec.tgt == TGT_BUF;
    assign txq_data = bus_wdata;
    assign rxq_pop  = bus_rd && dec.tgt == TGT_BUF;
endmodule

// File: rtl/spi_csr_bank_chk.sv
module spi_csr_bank_chk #(
    parameter int WA_W = 6
) (
    input logic            clk,
    input logic            rst_n,
    input logic            bus_wr,
    input logic            bus_rd,
    input logic [WA_W-1:0] bus_word,
    input logic [31:0]     bus_rdata,
    input logic [31:0]     ctrl_o,
    input logic            txq_push,
    input logic            rxq_pop,
    input logic            evt_rx_ovf,
    input logic [2:0]      flag_q
);
    logic ctrl_wr, stat_wr, rsv_rd;

    always_comb begin
        ctrl_wr = bus_wr && int'(bus_word) < 4;
        stat_wr = bus_wr && int'(bus_word) >= 4 && int'(bus_word) < 8;
        rsv_rd  = bus_rd && ((int'(bus_word) inside {9, 10, 11, 13, 14, 15})
                             || int'(bus_word) > 19);
    end

    AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_wr |=> $stable(ctrl_o)); // R3

    AST_PUSH_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        txq_push |-> (bus_wr && int'(bus_word) == 8)); // R11

    AST_POP_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        rxq_pop |-> (bus_rd && int'(bus_word) == 8)); // R11

    AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rsv_rd |-> bus_rdata == 32'd0); // R12

    AST_BAUD_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && int'(bus_word) == 12) |-> bus_rdata[31:9] == 23'd0); // R5

    AST_OVF_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        evt_rx_ovf |=> flag_q[0]); // R8

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q[0] && !stat_wr) |=> flag_q[0]); // R8
endmodule

bind spi_csr_bank spi_csr_bank_chk #(.WA_W(WA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_word   (bus_word),
    .bus_rdata  (bus_rdata),
    .ctrl_o     (ctrl_o),
    .txq_push   (txq_push),
    .rxq_pop    (rxq_pop),
    .evt_rx_ovf (evt_rx_ovf),
    .flag_q     (flag_q)
);

// File: tb/sim_spi_csr_bank.sv
module sim_spi_csr_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [5:0]  bus_word = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] ctrl_o, ctrl2_o, txq_data;
    logic [8:0]  baud_o;
    logic        txq_push, rxq_pop;
    logic [31:0] rxq_data = '0;
    logic [4:0]  txq_level = '0, rxq_level = '0;
    logic        rxq_empty = 1'b1;
    logic        evt_rx_ovf = 1'b0, evt_tx_udr = 1'b0, evt_frame = 1'b0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    string cur_tag = "";

    // behavioural reference state
    logic [31:0] m_ctrl = '0, m_ctrl2 = '0;
    logic [8:0]  m_baud = '0;
    bit   ovf_m = 0, udr_m = 0, frm_m = 0;

    always #4 clk = ~clk;

    spi_csr_bank u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_word(bus_word), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ctrl_o(ctrl_o), .ctrl2_o(ctrl2_o), .baud_o(baud_o),
        .txq_push(txq_push), .txq_data(txq_data), .rxq_pop(rxq_pop),
        .rxq_data(rxq_data), .txq_level(txq_level), .rxq_level(rxq_level),
        .rxq_empty(rxq_empty), .evt_rx_ovf(evt_rx_ovf),
        .evt_tx_udr(evt_tx_udr), .evt_frame(evt_frame)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic string tag_of(int w);
        if (cur_tag != "") return cur_tag;
        if (w == 0) return "R2";
        if (w < 4) return "R4";
        if (w < 8) return "R7";
        if (w == 8) return "R11";
        if (w == 12) return "R5";
        if (w >= 16 && w < 20) return "R6";
        return "R12";
    endfunction

    function automatic logic [31:0] ref_read(int w);
        logic [31:0] s;
        if (w < 4) return m_ctrl;
        if (w < 8) begin
            s = 32'd0;
            s[5] = rxq_empty;
            s[6] = ovf_m;
            s[8] = udr_m;
            s[12] = frm_m;
            s[20:16] = txq_level;
            s[28:24] = rxq_level;
            return s;
        end
        if (w == 8) return rxq_data;
        if (w == 12) return {23'd0, m_baud};
        if (w >= 16 && w < 20) return m_ctrl2;
        return 32'd0;
    endfunction

    function automatic logic [31:0] ref_op(int sub, logic [31:0] cur, logic [31:0] d);
        case (sub)
            0: return d;
            1: return cur & ~d;
            2: return cur | d;
            default: return cur ^ d;
        endcase
    endfunction

    task automatic ref_update(bit wr, int w, logic [31:0] d, logic [2:0] ev);
        logic [31:0] f;
        if (wr) begin
            if (w < 4) m_ctrl = ref_op(w % 4, m_ctrl, d);
            else if (w < 8) begin
                f = ref_op(w % 4, {19'd0, frm_m, 3'd0, udr_m, 1'b0, ovf_m, 6'd0}, d);
                ovf_m = f[6];
                udr_m = f[8];
                frm_m = f[12];
            end
            else if (w == 12) m_baud = d[8:0];
            else if (w >= 16 && w < 20) m_ctrl2 = ref_op(w % 4, m_ctrl2, d);
        end
        if (ev[0]) ovf_m = 1;
        if (ev[1]) udr_m = 1;
        if (ev[2]) frm_m = 1;
    endtask

    // one bus cycle: compare registered state, drive, compare combinational
    task automatic step(bit wr, bit rd, int w, logic [31:0] d, logic [2:0] ev);
        @(negedge clk);
        chk("R3", ctrl_o, m_ctrl);
        chk("R6", ctrl2_o, m_ctrl2);
        chk("R5", {23'd0, baud_o}, {23'd0, m_baud});
        bus_wr = wr;
        bus_rd = rd;
        bus_word = 6'(w);
        bus_wdata = d;
        {evt_frame, evt_tx_udr, evt_rx_ovf} = ev;
        #1;
        if (rd) chk(tag_of(w), bus_rdata, ref_read(w));
        chk("R11", {31'd0, txq_push}, {31'd0, wr && w == 8});
        chk("R11", {31'd0, rxq_pop}, {31'd0, rd && w == 8});
        if (wr && w == 8) chk("R11", txq_data, d);
        ref_update(wr, w, d, ev);
    endtask

    task automatic wr_(int w, logic [31:0] d); step(1, 0, w, d, 3'b000); endtask
    task automatic rd_(int w); step(0, 1, w, 32'd0, 3'b000); endtask

    initial begin
        logic [31:0] lfsr;
        // R1: state while and after reset
        repeat (3) @(negedge clk);
        chk("R1", ctrl_o, 32'd0);
        chk("R1", ctrl2_o, 32'd0);
        chk("R1", {23'd0, baud_o}, 32'd0);
        rst_n = 1'b1;
        cur_tag = "R1";
        rd_(0); rd_(4); rd_(12); rd_(16);
        cur_tag = "";

        // R2 / R3 / R4
        wr_(0, 32'hA5A5_0F0F); rd_(0);
        wr_(1, 32'h0000_0F00); rd_(0);
        wr_(2, 32'h00F0_0000); rd_(0);
        wr_(3, 32'hFFFF_0000); rd_(0);
        rd_(1); rd_(2); rd_(3);

        // R5
        wr_(12, 32'hFFFF_FFFF); rd_(12);
        wr_(12, 32'h0000_0123); rd_(12);

        // R6
        wr_(16, 32'h0000_0000);
        wr_(18, 32'h0000_1C00); rd_(16);
        wr_(17, 32'h0000_0800); rd_(17);
        wr_(19, 32'h0000_1400); rd_(18); rd_(19);

        // R7: live fields
        txq_level = 5'h13; rxq_level = 5'h07; rxq_empty = 1'b0;
        rd_(4); rd_(5);
        cur_tag = "R13";
        wr_(4, 32'hFFFF_FFFF); rd_(4);
        wr_(5, 32'hFFFF_FFFF); rd_(4);
        wr_(6, 32'h0000_1140); rd_(6);
        wr_(7, 32'h0000_0140); rd_(7);
        wr_(5, 32'h0000_1000); rd_(4);

        // R8: event capture and hold
        cur_tag = "R8";
        step(0, 0, 0, 32'd0, 3'b001);
        rd_(4); rd_(4);
        step(0, 0, 0, 32'd0, 3'b110);
        rd_(4);

        // R9: clear needs a 1
        cur_tag = "R9";
        wr_(5, 32'h0000_0000); rd_(4);
        wr_(5, 32'h0000_0040); rd_(4);
        wr_(5, 32'h0000_1100); rd_(4);

        // R10: event beats a same-cycle clear
        cur_tag = "R10";
        step(1, 0, 5, 32'h0000_1140, 3'b111);
        rd_(4);
        wr_(5, 32'h0000_1140); rd_(4);

        // R11: data window
        cur_tag = "R11";
        rxq_data = 32'hCAFE_0042;
        wr_(8, 32'h1234_5678);
        rd_(8);
        step(1, 1, 8, 32'h0BAD_F00D, 3'b000);

        // R12: reserved slots
        cur_tag = "R12";
        foreach (lfsr[i]) if (i < 1) begin end
        wr_(9, '1); wr_(10, '1); wr_(11, '1); wr_(13, '1);
        wr_(14, '1); wr_(15, '1); wr_(20, '1); wr_(63, '1);
        rd_(9); rd_(11); rd_(13); rd_(15); rd_(20); rd_(45); rd_(63);
        cur_tag = "";

        // mixed traffic compared against the reference every cycle
        lfsr = 32'h1ACE_B00C;
        for (int n = 0; n < 400; n++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            txq_level = lfsr[4:0];
            rxq_level = lfsr[9:5];
            rxq_empty = lfsr[10];
            rxq_data  = {lfsr[15:0], lfsr[31:16]};
            step(lfsr[11], lfsr[12], int'(lfsr[17:13]) % 24,
                 {lfsr[7:0], lfsr[31:8]},
                 {lfsr[20] & lfsr[19], lfsr[22] & lfsr[21], lfsr[24] & lfsr[23]});
        end
        step(0, 0, 0, 32'd0, 3'b000);
        step(0, 0, 0, 32'd0, 3'b000);

        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual hung expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule